// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two interrupt outputs of a two-port shared memory. Side A and side B each run on their own clock. Each side presents its chip-select pair, its read/write strobe and its internal access address, which is the address after any counter logic. From these the block builds a doorbell between the two sides. A write to the peer's mailbox word raises the peer's active-low interrupt. The owner of a raised interrupt drops it again by reading its own mailbox word.

The two mailbox words are the two highest addresses, and they move with the address-width parameter. The all-ones address belongs to side B. The all-ones address minus one belongs to side A. A raise request starts in the writer's clock domain and reaches the reader's domain as a toggle through a chain of synchronizer flops. The flag itself lives in the reader's domain. Each flag is a two-state machine with states `FLAG_RELEASED` (output high) and `FLAG_RAISED` (output low). It has these transitions:
- *raise*: a synchronized set event, taken from either state.
- *release*: a local clearing read with no set event in the same cycle, which goes from `FLAG_RAISED` to `FLAG_RELEASED`.
- *reset*: the domain's synchronous reset, which forces `FLAG_RELEASED`.

Top module: `mbox_irq_top`

## Requirements
- R1: A selected write (rw_a low) from side A to the all-ones address drives irq_n_b low. The change lands on exactly the SYNC_STAGES+1-th rising edge of clk_b after the clk_a edge that sampled the write, and never earlier. With SYNC_STAGES=2 this is the third clk_b edge.
- R2: A selected read (rw_b high) from side B of the all-ones address drives irq_n_b high on the same clk_b edge that samples the read.
- R3: A selected write from side B to the all-ones address minus one drives irq_n_a low on the SYNC_STAGES+1-th clk_a edge after the sampling clk_b edge. The flag then stays low through idle cycles and through repeated raises.
- R4: A selected read from side A of the all-ones address minus one drives irq_n_a high on the clk_a edge that samples it.
- R5: A side is selected only when its csn input is low and its cs input is high, both sampled on its own rising clock edge. An unselected access has no effect on either flag.
- R6: Selected accesses other than the four above leave both flags unchanged. This covers reading the peer's mailbox word, writing one's own mailbox word, and any other address, including the all-ones value of a narrower width.
- R7: If a synchronized set event and a clearing read reach the same flag on the same edge, the flag ends up low (set wins).
- R8: A synchronous reset on a side's own clock releases that side's flag (output high) from the first edge at which reset is sampled high, including when the flag was low before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a | input | 1 | Side A synchronous reset, active high |
| csn_a | input | 1 | Side A chip select, active low |
| cs_a | input | 1 | Side A chip select, active high |
| rw_a | input | 1 | Side A direction: 1 read, 0 write |
| addr_a | input | AW | Side A internal access address |
| irq_n_a | output | 1 | Side A interrupt, active low |
| clk_b | input | 1 | Side B clock |
| rst_b | input | 1 | Side B synchronous reset, active high |
| csn_b | input | 1 | Side B chip select, active low |
| cs_b | input | 1 | Side B chip select, active high |
| rw_b | input | 1 | Side B direction: 1 read, 0 write |
| addr_b | input | AW | Side B internal access address |
| irq_n_b | output | 1 | Side B interrupt, active low |

## Verification
A clearing read acts on the very edge that samples it. The bench therefore checks the flag half a time unit after that edge. A raise crosses domains, so the bench counts destination-clock edges after the writer's sampling edge. It checks the flag is still high after SYNC_STAGES edges and low after one edge more. The set-wins case times a clearing read so that it is sampled on exactly that SYNC_STAGES+1-th edge. The two clock periods are chosen so that their edges never coincide, which makes every edge count exact.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    typedef enum logic {
        FLAG_RELEASED = 1'b0,
        FLAG_RAISED   = 1'b1
    } flag_state_t;

    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/mbox_req_decode.sv
module mbox_req_decode #(
    parameter int            AW        = 18,
    parameter logic [AW-1:0] OWN_ADDR  = '1,
    parameter logic [AW-1:0] PEER_ADDR = '0
) (
    input  logic          csn,
    input  logic          cs,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    output logic          raise_peer,
    output logic          clear_own
);

    logic selected;

    always_comb begin
        selected   = !csn && cs;
        raise_peer = selected && !rw && (addr == PEER_ADDR);
        clear_own  = selected &&  rw && (addr == OWN_ADDR);
    end

endmodule

// File: rtl/mbox_evt_cdc.sv
module mbox_evt_cdc #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_req,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_evt
);

    logic              tgl_q;
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // source domain: one flip per request
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            tgl_q <= 1'b0;
        end else if (src_req) begin
            tgl_q <= ~tgl_q;
        end
    end

    // destination domain: synchronizer chain plus change detector
    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tgl_q};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign dst_evt = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq_n
);

    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_RELEASED: begin
                if (set_evt) state_d = FLAG_RAISED;
            end
            FLAG_RAISED: begin
                if (clr_evt && !set_evt) state_d = FLAG_RELEASED;
            end
            default: state_d = FLAG_RELEASED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLAG_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_n = (state_q == FLAG_RELEASED);
    end

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
    import mbox_irq_pkg::*;
#(
    parameter int AW          = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_a,
    input  logic          rst_a,
    input  logic          csn_a,
    input  logic          cs_a,
    input  logic          rw_a,
    input  logic [AW-1:0] addr_a,
    output logic          irq_n_a,
    input  logic          clk_b,
    input  logic          rst_b,
    input  logic          csn_b,
    input  logic          cs_b,
    input  logic          rw_b,
    input  logic [AW-1:0] addr_b,
    output logic          irq_n_b
);

    localparam logic [AW-1:0] TOP_ADDR   = '1;
    localparam logic [AW-1:0] BELOW_ADDR = TOP_ADDR - 1'b1;

    logic                 clk_v   [NUM_SIDES];
    logic                 rst_v   [NUM_SIDES];
    logic                 csn_v   [NUM_SIDES];
    logic                 cs_v    [NUM_SIDES];
    logic                 rw_v    [NUM_SIDES];
    logic [AW-1:0]        addr_v  [NUM_SIDES];
    logic [NUM_SIDES-1:0] raise_v;
    logic [NUM_SIDES-1:0] clear_v;
    logic [NUM_SIDES-1:0] set_evt;
    logic [NUM_SIDES-1:0] irq_n_v;

    assign clk_v[SIDE_A]  = clk_a;
    assign clk_v[SIDE_B]  = clk_b;
    assign rst_v[SIDE_A]  = rst_a;
    assign rst_v[SIDE_B]  = rst_b;
    assign csn_v[SIDE_A]  = csn_a;
    assign csn_v[SIDE_B]  = csn_b;
    assign cs_v[SIDE_A]   = cs_a;
    assign cs_v[SIDE_B]   = cs_b;
    assign rw_v[SIDE_A]   = rw_a;
    assign rw_v[SIDE_B]   = rw_b;
    assign addr_v[SIDE_A] = addr_a;
    assign addr_v[SIDE_B] = addr_b;

    for (genvar p = 0; p < NUM_SIDES; p++) begin : g_side
        localparam int            PEER = NUM_SIDES - 1 - p;
        localparam logic [AW-1:0] OWN_MBOX  = (p == SIDE_A) ? BELOW_ADDR : TOP_ADDR;
        localparam logic [AW-1:0] PEER_MBOX = (p == SIDE_A) ? TOP_ADDR : BELOW_ADDR;

        mbox_req_decode #(
            .AW        (AW),
            .OWN_ADDR  (OWN_MBOX),
            .PEER_ADDR (PEER_MBOX)
        ) u_decode (
            .csn        (csn_v[p]),
            .cs         (cs_v[p]),
            .rw         (rw_v[p]),
            .addr       (addr_v[p]),
            .raise_peer (raise_v[p]),
            .clear_own  (clear_v[p])
        );

        mbox_evt_cdc #(
            .STAGES (SYNC_STAGES)
        ) u_cdc (
            .src_clk (clk_v[PEER]),
            .src_rst (rst_v[PEER]),
            .src_req (raise_v[PEER]),
            .dst_clk (clk_v[p]),
            .dst_rst (rst_v[p]),
            .dst_evt (set_evt[p])
        );

        mbox_flag_fsm u_flag (
            .clk     (clk_v[p]),
            .rst     (rst_v[p]),
            .set_evt (set_evt[p]),
            .clr_evt (clear_v[p]),
            .irq_n   (irq_n_v[p])
        );
    end

    assign irq_n_a = irq_n_v[SIDE_A];
    assign irq_n_b = irq_n_v[SIDE_B];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int AW = 18
) (
    input logic          clk_a,
    input logic          rst_a,
    input logic          csn_a,
    input logic          cs_a,
    input logic          rw_a,
    input logic [AW-1:0] addr_a,
    input logic          irq_n_a,
    input logic          clk_b,
    input logic          rst_b,
    input logic          csn_b,
    input logic          cs_b,
    input logic          rw_b,
    input logic [AW-1:0] addr_b,
    input logic          irq_n_b,
    input logic [1:0]    set_evt
);

    localparam logic [AW-1:0] TOP_ADDR   = '1;
    localparam logic [AW-1:0] BELOW_ADDR = TOP_ADDR - 1'b1;

    logic a_rd_own, b_rd_own;
    assign a_rd_own = !csn_a && cs_a && rw_a && (addr_a == BELOW_ADDR);
    assign b_rd_own = !csn_b && cs_b && rw_b && (addr_b == TOP_ADDR);

    AST_A_RESET_RELEASE: assert property (@(posedge clk_a) rst_a |=> irq_n_a);  // R8
    AST_B_RESET_RELEASE: assert property (@(posedge clk_b) rst_b |=> irq_n_b);  // R8

    AST_A_SET_WINS: assert property (@(posedge clk_a) disable iff (rst_a)
        set_evt[0] |=> !irq_n_a);  // R7
    AST_B_SET_WINS: assert property (@(posedge clk_b) disable iff (rst_b)
        set_evt[1] |=> !irq_n_b);  // R7

    AST_A_FALL_CAUSE: assert property (@(posedge clk_a) disable iff (rst_a)
        $fell(irq_n_a) |-> $past(set_evt[0]));  // R3
    AST_B_FALL_CAUSE: assert property (@(posedge clk_b) disable iff (rst_b)
        $fell(irq_n_b) |-> $past(set_evt[1]));  // R1

    AST_A_READ_CLEARS: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_rd_own && !set_evt[0]) |=> irq_n_a);  // R4
    AST_B_READ_CLEARS: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_rd_own && !set_evt[1]) |=> irq_n_b);  // R2

    AST_A_RISE_CAUSE: assert property (@(posedge clk_a) disable iff (rst_a)
        $rose(irq_n_a) |-> $past(a_rd_own));  // R5
    AST_B_RISE_CAUSE: assert property (@(posedge clk_b) disable iff (rst_b)
        $rose(irq_n_b) |-> $past(b_rd_own));  // R6

endmodule

bind mbox_irq_top mbox_irq_chk #(.AW(AW)) u_mbox_irq_chk (
    .clk_a   (clk_a),
    .rst_a   (rst_a),
    .csn_a   (csn_a),
    .cs_a    (cs_a),
    .rw_a    (rw_a),
    .addr_a  (addr_a),
    .irq_n_a (irq_n_a),
    .clk_b   (clk_b),
    .rst_b   (rst_b),
    .csn_b   (csn_b),
    .cs_b    (cs_b),
    .rw_b    (rw_b),
    .addr_b  (addr_b),
    .irq_n_b (irq_n_b),
    .set_evt (set_evt)
);

// File: tb/test_mbox_irq_top.sv
`timescale 1ns/100ps
module test_mbox_irq_top;

    localparam int AW = 18;
    localparam int SYNC = 2;
    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 12;
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] BELOW = TOP - 1'b1;
    localparam logic RD = 1'b1;
    localparam logic WR = 1'b0;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1;
    logic csn_a = 1'b1, cs_a = 1'b0, rw_a = 1'b1;
    logic csn_b = 1'b1, cs_b = 1'b0, rw_b = 1'b1;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic irq_n_a, irq_n_b;

    int checks = 0;
    int fails = 0;

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    mbox_irq_top #(.AW(AW), .SYNC_STAGES(SYNC)) i_mbox_irq_top (
        .clk_a, .rst_a, .csn_a, .cs_a, .rw_a, .addr_a, .irq_n_a,
        .clk_b, .rst_b, .csn_b, .cs_b, .rw_b, .addr_b, .irq_n_b
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic access_a(input logic rw, input logic [AW-1:0] ad, input logic cn, input logic c);
        @(negedge clk_a);
        csn_a = cn; cs_a = c; rw_a = rw; addr_a = ad;
        @(posedge clk_a);
        #0.2;
        csn_a = 1'b1; cs_a = 1'b0; rw_a = 1'b1; addr_a = '0;
    endtask

    task automatic access_b(input logic rw, input logic [AW-1:0] ad, input logic cn, input logic c);
        @(negedge clk_b);
        csn_b = cn; cs_b = c; rw_b = rw; addr_b = ad;
        @(posedge clk_b);
        #0.2;
        csn_b = 1'b1; cs_b = 1'b0; rw_b = 1'b1; addr_b = '0;
    endtask

    task automatic t_reset_state();
        check(irq_n_a, 1'b1, "R8 side A released after reset");
        check(irq_n_b, 1'b1, "R8 side B released after reset");
    endtask

    task automatic t_raise_b();
        access_a(WR, TOP, 1'b0, 1'b1);
        repeat (SYNC) @(posedge clk_b);
        #0.5 check(irq_n_b, 1'b1, "R1 not early");
        @(posedge clk_b);
        #0.5 check(irq_n_b, 1'b0, "R1 raised on edge SYNC+1");
    endtask

    task automatic t_clear_b();
        access_b(RD, TOP, 1'b0, 1'b1);
        #0.3 check(irq_n_b, 1'b1, "R2 read releases side B");
    endtask

    task automatic t_raise_a();
        access_b(WR, BELOW, 1'b0, 1'b1);
        repeat (SYNC) @(posedge clk_a);
        #0.5 check(irq_n_a, 1'b1, "R3 not early");
        @(posedge clk_a);
        #0.5 check(irq_n_a, 1'b0, "R3 raised on edge SYNC+1");
    endtask

    task automatic t_clear_a();
        access_a(RD, BELOW, 1'b0, 1'b1);
        #0.3 check(irq_n_a, 1'b1, "R4 read releases side A");
    endtask

    task automatic t_hold_a();
        t_raise_a();
        repeat (10) @(posedge clk_a);
        #0.5 check(irq_n_a, 1'b0, "R3 holds through idle");
        access_b(WR, BELOW, 1'b0, 1'b1);
        repeat (SYNC + 3) @(posedge clk_a);
        #0.5 check(irq_n_a, 1'b0, "R3 holds through repeat raise");
        t_clear_a();
    endtask

    task automatic t_deselect();
        access_a(WR, TOP, 1'b1, 1'b1);
        access_a(WR, TOP, 1'b0, 1'b0);
        access_b(WR, BELOW, 1'b1, 1'b0);
        repeat (SYNC + 4) @(posedge clk_b);
        #0.5 check(irq_n_b, 1'b1, "R5 unselected write ignored (B)");
        check(irq_n_a, 1'b1, "R5 unselected write ignored (A)");
        t_raise_b();
        access_b(RD, TOP, 1'b1, 1'b1);
        #0.3 check(irq_n_b, 1'b0, "R5 csn high read does not release");
        access_b(RD, TOP, 1'b0, 1'b0);
        #0.3 check(irq_n_b, 1'b0, "R5 cs low read does not release");
        t_clear_b();
    endtask

    task automatic t_ignored();
        access_a(RD, TOP, 1'b0, 1'b1);
        access_a(WR, BELOW, 1'b0, 1'b1);
        access_b(WR, TOP, 1'b0, 1'b1);
        access_b(RD, BELOW, 1'b0, 1'b1);
        access_a(WR, TOP >> 1, 1'b0, 1'b1);
        access_b(WR, BELOW >> 1, 1'b0, 1'b1);
        repeat (SYNC + 4) @(posedge clk_b);
        #0.5 check(irq_n_b, 1'b1, "R6 other accesses leave B released");
        check(irq_n_a, 1'b1, "R6 other accesses leave A released");
        t_raise_b();
        access_b(WR, TOP, 1'b0, 1'b1);
        #0.3 check(irq_n_b, 1'b0, "R6 write of own mailbox does not release");
        access_a(RD, TOP, 1'b0, 1'b1);
        repeat (SYNC + 3) @(posedge clk_b);
        #0.5 check(irq_n_b, 1'b0, "R6 peer read does not release");
        t_clear_b();
    endtask

    task automatic t_set_wins();
        access_a(WR, TOP, 1'b0, 1'b1);
        repeat (SYNC) @(posedge clk_b);
        access_b(RD, TOP, 1'b0, 1'b1);
        #0.3 check(irq_n_b, 1'b0, "R7 set wins over clear on same edge");
        t_clear_b();
    endtask

    task automatic t_reset_mid();
        t_raise_a();
        t_raise_b();
        @(negedge clk_a);
        rst_a = 1'b1; rst_b = 1'b1;
        repeat (3) @(posedge clk_b);
        #0.5 check(irq_n_a, 1'b1, "R8 reset releases raised A");
        check(irq_n_b, 1'b1, "R8 reset releases raised B");
        @(negedge clk_a);
        rst_a = 1'b0; rst_b = 1'b0;
        repeat (4) @(posedge clk_b);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(200000 * CLK_A_PERIOD);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (6) @(posedge clk_b);
        @(negedge clk_a);
        rst_a = 1'b0; rst_b = 1'b0;
        #0.5;
        t_reset_state();
        t_raise_b();
        t_clear_b();
        t_raise_a();
        t_clear_a();
        t_hold_a();
        t_deselect();
        t_ignored();
        t_set_wins();
        t_reset_mid();
        t_raise_b();
        t_clear_b();
        summary();
        $finish;
    end

endmodule